// File: doc/BRIEF.md
# Programmable Postscaler Clock Divider

This block turns a stream of fast input cycles into a slower divided clock. A 3-bit ratio code chooses the divide ratio from a fixed set that includes odd and non-power-of-two values. Each divided period is given in two forms. The first is a registered square wave, `divClk`. The second is a one-cycle strobe, `divEn`, which downstream logic can use as a clock enable. The strobe is high in the same cycle in which the square wave goes high.

The block runs on a single clock. Two upstream sources are each modelled as a per-cycle tick. A 1-bit source select picks which tick counts as an input cycle. When no tick is present on the selected source, the divider simply waits. A new ratio code only takes effect where one period ends and the next begins, so a period is never cut short. A divider-reset input stops the output and masks the ratio code. Once it is released, the first divided period starts from a clean low phase.

Top module: `pscale_div`

## Requirements
- R1: While `rstN` is low, `divClk` and `divEn` are 0.
- R2: The ratio code maps to a period, measured in active ticks, as follows: 0→1, 1→2, 2→3, 3→4, 4→6, 5→8, 6→12, 7→12. The period is the distance between successive `divEn` pulses.
- R3: In each period of ratio N, `divClk` is high for max(1, floor(N/2)) active ticks and low for the rest. This gives a 50% duty cycle for even N, a high phase one tick shorter than the low phase for N=3, and a constant 1 for N=1. `divClk` only rises together with a `divEn` pulse.
- R4: `divEn` is high for exactly the cycle in which a new period begins, and `divClk` is high in that cycle. With ratio 1 and a tick on every cycle, `divEn` is high on every cycle.
- R5: `ratioSel` is sampled only at the tick that ends a period. A change in the middle of a period leaves that period's length unchanged and applies from the next period.
- R6: While `divRst` is 1, `divClk` and `divEn` are 0 from the next cycle on, and `ratioSel` has no effect.
- R7: After `divRst` falls, the ratio is taken from `ratioSel` at the first active tick. The first `divEn` (and the first `divClk` rise) follows the N-th active tick after release, and `divClk` stays low before it.
- R8: `srcSel`=0 counts `srcTick0` and `srcSel`=1 counts `srcTick1`. Ticks on the unselected source have no effect. In a cycle with no selected tick, `divClk` holds and `divEn` is 0.
- R9: Both outputs are registered. They change one clock after the tick that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcTick0 | input | 1 | Input-cycle tick from source 0 |
| srcTick1 | input | 1 | Input-cycle tick from source 1 |
| srcSel | input | 1 | Source select (0: source 0, 1: source 1) |
| divRst | input | 1 | Divider reset; stops output and masks ratio code |
| ratioSel | input | 3 | Divide-ratio code |
| divClk | output | 1 | Divided square-wave clock |
| divEn | output | 1 | One-cycle strobe at the start of each period |

## Verification
A wrong count or a wrong latched ratio appears as a `divEn` gap that differs from the table, and a wrong phase threshold appears as a `divClk` fall in the wrong cycle. Either shows up within one divided period, at most twelve active ticks. A fault in the start-up state after divider reset shows as an early or late first pulse, or as a stray high `divClk` before that pulse. The bench model is compared on every clock, so any of these errors is reported in the cycle where it first appears.

// File: rtl/pscale_pkg.sv
package pscale_pkg;

  localparam int SEL_W   = 3;
  localparam int RATIO_W = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;    // hold stopped
    logic step;     // one active input tick
    logic wrap;     // this tick closes the period
    logic lowHold;  // keep divClk low (start-up fill)
  } pscStrobe_t;

  function automatic logic [RATIO_W-1:0] ratioOf(input logic [SEL_W-1:0] code);
    logic [RATIO_W-1:0] r;
    case (code)
      3'd0:    r = RATIO_W'(1);
      3'd1:    r = RATIO_W'(2);
      3'd2:    r = RATIO_W'(3);
      3'd3:    r = RATIO_W'(4);
      3'd4:    r = RATIO_W'(6);
      3'd5:    r = RATIO_W'(8);
      default: r = RATIO_W'(12);
    endcase
    return r;
  endfunction

  function automatic logic [RATIO_W-1:0] highOf(input logic [RATIO_W-1:0] ratio);
    logic [RATIO_W-1:0] h;
    h = ratio >> 1;
    if (h == '0) h = RATIO_W'(1);
    return h;
  endfunction

endpackage

// File: rtl/pscale_ctrl.sv
module pscale_ctrl
  import pscale_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int RW = RATIO_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          srcTick0,
  input  logic          srcTick1,
  input  logic          srcSel,
  input  logic          divRst,
  input  logic [SW-1:0] ratioSel,
  input  logic          atTerm,
  output pscStrobe_t    strb,
  output logic [RW-1:0] curRatio
);

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_RUN} phase_t;

  phase_t        phase;
  logic          activeTick;
  logic [RW-1:0] selRatio;

  assign activeTick = srcSel ? srcTick1 : srcTick0;
  assign selRatio   = RW'(ratioOf(SEL_W'(ratioSel)));

  always_comb begin
    strb         = '0;
    strb.clear   = divRst;
    strb.lowHold = (phase != ST_RUN);
    if (!divRst && activeTick) begin
      strb.step = 1'b1;
      if (phase == ST_IDLE) strb.wrap = (selRatio == RW'(1));
      else                  strb.wrap = atTerm;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= ST_IDLE;
      curRatio <= RW'(1);
    end else if (divRst) begin
      phase    <= ST_IDLE;
    end else if (strb.wrap) begin
      phase    <= ST_RUN;
      curRatio <= selRatio;
    end else if (strb.step && phase == ST_IDLE) begin
      phase    <= ST_FILL;
      curRatio <= selRatio;
    end
  end

endmodule

// File: rtl/pscale_dp.sv
module pscale_dp
  import pscale_pkg::*;
#(
  parameter int RW = RATIO_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  pscStrobe_t    strb,
  input  logic [RW-1:0] curRatio,
  output logic          atTerm,
  output logic [RW-1:0] cntOut,
  output logic          divClk,
  output logic          divEn
);

  logic [RW-1:0] cnt;
  logic [RW-1:0] nextCnt;
  logic [RW-1:0] hiCnt;

  assign nextCnt = cnt + RW'(1);
  assign hiCnt   = RW'(highOf(RATIO_W'(curRatio)));
  assign atTerm  = (cnt == curRatio - RW'(1));
  assign cntOut  = cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      divClk <= 1'b0;
      divEn  <= 1'b0;
    end else if (strb.clear) begin
      cnt    <= '0;
      divClk <= 1'b0;
      divEn  <= 1'b0;
    end else if (strb.wrap) begin
      cnt    <= '0;
      divClk <= 1'b1;
      divEn  <= 1'b1;
    end else if (strb.step) begin
      cnt    <= nextCnt;
      divClk <= !strb.lowHold && (nextCnt < hiCnt);
      divEn  <= 1'b0;
    end else begin
      divEn  <= 1'b0;
    end
  end

endmodule

// File: rtl/pscale_div.sv
module pscale_div
  import pscale_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             srcTick0,
  input  logic             srcTick1,
  input  logic             srcSel,
  input  logic             divRst,
  input  logic [SEL_W-1:0] ratioSel,
  output logic             divClk,
  output logic             divEn
);

  pscStrobe_t         strb;
  logic [RATIO_W-1:0] curRatio;
  logic [RATIO_W-1:0] dpCnt;
  logic               atTerm;

  pscale_ctrl #(.SW(SEL_W), .RW(RATIO_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .srcTick0(srcTick0), .srcTick1(srcTick1),
    .srcSel(srcSel), .divRst(divRst), .ratioSel(ratioSel),
    .atTerm(atTerm), .strb(strb), .curRatio(curRatio)
  );

  pscale_dp #(.RW(RATIO_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .curRatio(curRatio),
    .atTerm(atTerm), .cntOut(dpCnt), .divClk(divClk), .divEn(divEn)
  );

endmodule

// File: rtl/pscale_div_chk.sv
module pscale_div_chk (
  input logic       clk,
  input logic       rstN,
  input logic       srcTick0,
  input logic       srcTick1,
  input logic       srcSel,
  input logic       divRst,
  input logic       divClk,
  input logic       divEn,
  input logic [4:0] curRatio,
  input logic [4:0] cntVal
);

  a_r4_en_with_clk: assert property (@(posedge clk) disable iff (!rstN)
    divEn |-> divClk);

  a_r3_rise_needs_en: assert property (@(posedge clk) disable iff (!rstN)
    $rose(divClk) |-> divEn);

  a_r6_rst_quiet: assert property (@(posedge clk) disable iff (!rstN)
    divRst |=> (!divClk && !divEn));

  a_r8_no_tick_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!divRst && !(srcSel ? srcTick1 : srcTick0)) |=> ($stable(divClk) && !divEn));

  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rstN)
    cntVal < curRatio);

endmodule

bind pscale_div pscale_div_chk chk_i (
  .clk(clk), .rstN(rstN), .srcTick0(srcTick0), .srcTick1(srcTick1),
  .srcSel(srcSel), .divRst(divRst), .divClk(divClk), .divEn(divEn),
  .curRatio(curRatio), .cntVal(dpCnt)
);

// File: tb/pscale_div_tb_top.sv
`timescale 1ns/1ps
module pscale_div_tb_top;

  logic       clk = 1'b0;
  logic       rstN, srcTick0, srcTick1, srcSel, divRst;
  logic [2:0] ratioSel;
  logic       divClk, divEn;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  string curReq = "R9";

  always #4 clk = ~clk;  // 125 MHz

  pscale_div dut_i (
    .clk(clk), .rstN(rstN), .srcTick0(srcTick0), .srcTick1(srcTick1),
    .srcSel(srcSel), .divRst(divRst), .ratioSel(ratioSel),
    .divClk(divClk), .divEn(divEn)
  );

  function automatic int tblRatio(input int code);
    case (code)
      0: return 1;  1: return 2;  2: return 3;  3: return 4;
      4: return 6;  5: return 8;  default: return 12;
    endcase
  endfunction

  // behavioural reference: mode 0 stopped, 1 first fill, 2 running
  int mMode = 0, mCnt = 0, mRatio = 1;
  bit mClk = 0, mEn = 0;

  always @(posedge clk) begin
    bit tick;
    int hi;
    if (!rstN || divRst) begin
      mMode = 0; mCnt = 0; mClk = 0; mEn = 0;
    end else begin
      tick = srcSel ? srcTick1 : srcTick0;
      if (!tick) mEn = 0;
      else if ((mMode == 0 && tblRatio(int'(ratioSel)) == 1) ||
               (mMode != 0 && mCnt == mRatio - 1)) begin
        mRatio = tblRatio(int'(ratioSel));
        mCnt = 0; mClk = 1; mEn = 1; mMode = 2;
      end else if (mMode == 0) begin
        mRatio = tblRatio(int'(ratioSel));
        mCnt = 1; mClk = 0; mEn = 0; mMode = 1;
      end else begin
        mCnt++;
        hi = (mRatio / 2 < 1) ? 1 : mRatio / 2;
        mClk = (mMode == 2) && (mCnt < hi);
        mEn = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // every-cycle comparison against the model (R9 registered timing)
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      check(divClk == mClk, curReq, "divClk vs model", int'(divClk), int'(mClk));
      check(divEn == mEn, curReq, "divEn vs model", int'(divEn), int'(mEn));
    end
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 50000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic waitEn(output bit found);
    found = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (divEn) begin found = 1; break; end
    end
  endtask

  // cycles from one divEn to the next, and divClk-high cycles in between
  task automatic gapAfterEn(output int gap, output int hiN);
    gap = 0; hiN = 1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      gap++;
      if (divEn) break;
      if (divClk) hiN++;
    end
  endtask

  initial begin
    bit f;
    int gap, hiN, expHi, n;
    bit held;
    logic [15:0] lfsr;
    rstN = 0; srcTick0 = 1; srcTick1 = 1; srcSel = 0; divRst = 0; ratioSel = 3'd0;
    repeat (3) @(negedge clk);
    check(divClk == 0 && divEn == 0, "R1", "outputs in reset",
          int'({divClk, divEn}), 0);
    rstN = 1;

    // R4: ratio 1, tick every cycle
    curReq = "R4";
    repeat (2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(divEn && divClk, "R4", "divide-by-1 strobe", int'({divClk, divEn}), 3);
    end

    // R2 / R3: every code
    for (int code = 0; code < 8; code++) begin
      curReq = "R2";
      ratioSel = 3'(code);
      waitEn(f);
      check(f, "R2", "pulse found", int'(f), 1);
      gapAfterEn(gap, hiN);
      check(gap == tblRatio(code), "R2", "period", gap, tblRatio(code));
      expHi = (tblRatio(code) / 2 < 1) ? 1 : tblRatio(code) / 2;
      check(hiN == expHi, "R3", "high phase", hiN, expHi);
    end

    // R5: change mid-period
    curReq = "R5";
    ratioSel = 3'd6;
    waitEn(f);
    waitEn(f);
    n = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      n++;
      if (n == 3) ratioSel = 3'd0;
      if (divEn) break;
    end
    check(n == 12, "R5", "period kept after mid change", n, 12);
    @(negedge clk);
    check(divEn == 1, "R5", "new ratio from next period", int'(divEn), 1);

    // R6: divider reset masks select
    curReq = "R6";
    divRst = 1;
    for (int i = 0; i < 20; i++) begin
      ratioSel = 3'(i);
      @(negedge clk);
      check(!divClk && !divEn, "R6", "stopped under divRst", int'({divClk, divEn}), 0);
    end

    // R7: release with ratio 6
    curReq = "R7";
    ratioSel = 3'd4;
    divRst = 0;
    n = 0; held = 1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      n++;
      if (divEn) break;
      if (divClk) held = 0;
    end
    check(n == 6, "R7", "first pulse after release", n, 6);
    check(held, "R7", "low before first pulse", int'(held), 1);

    // R8: unselected source ignored
    curReq = "R8";
    srcSel = 1; srcTick1 = 0; srcTick0 = 1;
    @(negedge clk);
    held = divClk; f = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (divEn || divClk != held) f = 1;
    end
    check(!f, "R8", "no change from unselected ticks", int'(f), 0);
    srcTick1 = 1;
    waitEn(f);
    check(f, "R8", "selected source runs", int'(f), 1);

    // mixed tick patterns, model compared every cycle (R9)
    curReq = "R9";
    lfsr = 16'hACE1;
    for (int i = 0; i < 900; i++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      srcTick0 = lfsr[0] | lfsr[3];
      srcTick1 = lfsr[5];
      if (i % 64 == 0) srcSel = ~srcSel;
      if (i % 29 == 0) ratioSel = lfsr[10:8];
      divRst = (i % 150) >= 145;
    end
    divRst = 0;
    repeat (4) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule